// File: doc/BRIEF.md
# Sample-Clock Prescaler and Power Sequencer

This block runs on a fixed 2.000 MHz master clock and produces the internal timing of a voiceband codec. It issues a 256 kHz clock enable and an 8 kHz sample strobe, and keeps both in phase with an external 8 kHz frame sync. 2000/256 is not an integer. The 256 kHz enable therefore comes from a fractional accumulator that yields 16 pulses in every 125 master cycles, spaced 7 or 8 cycles apart. Every frame-sync rising edge restarts both the accumulator and the 8 kHz phase.

The block also sequences power. With the power-up pin low, the block is off. With the pin high and no frame sync, it waits in standby. The first frame-sync rising edge wakes it. If sync then stops for more than a frame, it drops back to standby. After each wake, transmit permission is held off for two frame periods so that the serial port cannot drive the bus too early. All pins are plain level control and status signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `smpclk_pwr_seq`

## Requirements
- R1: While running, `ce_fast_o` pulses exactly 32 times in a 250-cycle frame. Cycle k after the last sync rise (k = 0..249) carries a pulse when k = 0 or when floor(16k/125) differs from floor(16(k-1)/125).
- R2: A sync rise restarts the fractional phase. The cycle after the edge at which `fsync_i` is first sampled high always carries a `ce_fast_o` pulse, wherever the previous phase stood.
- R3: `smp_stb_o` is a one-cycle pulse in the cycle after the edge where `fsync_i` is first sampled high, provided that edge wakes or keeps the block running. Holding `fsync_i` high produces no further strobe.
- R4: While running, if no sync rise is sampled at any of the 251 edges that follow the last rise, the block enters standby after that 251st edge. `standby_o` goes to 1, `powered_o` to 0, and enables and strobe stop. A rise exactly 251 edges after the previous one still keeps the block running.
- R5: In standby with `pwr_up_i` high, a sync rise makes `powered_o` 1 in the next cycle. In that same cycle `ce_fast_o` and `smp_stb_o` pulse.
- R6: `pwr_up_i` low at an edge puts the block in the off state from the next cycle: `standby_o`, `powered_o`, `tx_en_o`, `ce_fast_o` and `smp_stb_o` are all 0. Sync edges have no effect while off. A rise sampled at the same edge where the pin returns high does not wake the block; the block only enters standby there.
- R7: After every wake, `tx_en_o` stays 0 until the second sync rise that follows the waking rise. It is 1 from the cycle after that rise, and 0 whenever the block is not running.
- R8: After reset, `standby_o` is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.000 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | External 8 kHz frame sync, synchronous to `clk` |
| pwr_up_i | input | 1 | Power-up request; low forces the off state |
| ce_fast_o | output | 1 | 256 kHz clock enable, one master cycle wide |
| smp_stb_o | output | 1 | 8 kHz sample strobe, one master cycle wide |
| standby_o | output | 1 | High while waiting for frame sync |
| powered_o | output | 1 | High while running |
| tx_en_o | output | 1 | Transmit-output permission for the PCM port |

## Verification
A corrupted fractional accumulator shows within one 256 kHz period (8 master cycles) as a misplaced `ce_fast_o` pulse. It persists until the next sync rise clears it. A wrong silence count shows as standby entered a cycle early or late around the 251st edge. Such a fault appears only when sync is late or missing, so the stimulus includes a sync exactly 251 edges late and a long gap. A fault in the guard counter shows as `tx_en_o` rising one frame early or late after a wake. It is checked after a wake from reset, a wake from standby and a wake from the off state.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_IDLE = 2'd1,
    PS_RUN  = 2'd2
  } pwr_st_t;

  // greatest common divisor, used to reduce the clock ratio
  function automatic int gcd_i(int a, int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

endpackage

// File: rtl/pcd_edge_mon.sv
module pcd_edge_mon #(
  parameter int FRAME_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  input  logic run_i,
  output logic rise_o,
  output logic lapse_o
);
  localparam int CW = $clog2(FRAME_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FRAME_CYC);

  logic          fs_q;
  logic [CW-1:0] quiet_cnt;

  assign rise_o  = fsync_i & ~fs_q;
  assign lapse_o = run_i & ~rise_o & (quiet_cnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      fs_q <= fsync_i;
      if (!run_i || rise_o)
        quiet_cnt <= '0;
      else if (quiet_cnt != LIM)
        quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // R4: silence counter never runs past its limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_cnt <= LIM);

  // R4: a lapse only after at least one quiet cycle
  a_r4_lapse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lapse_o |-> !fsync_i || fs_q);

endmodule

// File: rtl/pcd_frac_div.sv
module pcd_frac_div #(
  parameter int NUM = 16,
  parameter int DEN = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int AW = $clog2(DEN + NUM + 1);
  localparam logic [AW-1:0] STEP = AW'(NUM);
  localparam logic [AW-1:0] MODV = AW'(DEN);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum = acc + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      acc    <= '0;
      tick_o <= 1'b1;
    end else if (sum >= MODV) begin
      acc    <= sum - MODV;
      tick_o <= 1'b1;
    end else begin
      acc    <= sum;
      tick_o <= 1'b0;
    end
  end

  // R1: accumulator residue stays below the modulus
  a_r1_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc < MODV);

  // R2: a restart always yields a tick next cycle
  a_r2_restart_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && restart_i) |=> tick_o);

endmodule

// File: rtl/pcd_pwr_seq.sv
module pcd_pwr_seq
  import pcd_pkg::*;
#(
  parameter int GUARD = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_up_i,
  input  logic    rise_i,
  input  logic    lapse_i,
  output pwr_st_t state_o,
  output logic    active_o,
  output logic    tx_en_o
);
  localparam int GW = $clog2(GUARD + 1);
  localparam logic [GW-1:0] GLOAD = GW'(GUARD);

  pwr_st_t       st;
  pwr_st_t       st_nx;
  logic [GW-1:0] guard;
  logic          wake;

  assign wake     = pwr_up_i & rise_i & (st == PS_IDLE);
  assign active_o = pwr_up_i & (((st == PS_RUN) & ~lapse_i) | ((st == PS_IDLE) & rise_i));
  assign tx_en_o  = (st == PS_RUN) & (guard == '0);
  assign state_o  = st;

  always_comb begin
    st_nx = st;
    if (!pwr_up_i) begin
      st_nx = PS_OFF;
    end else begin
      unique case (st)
        PS_OFF:  st_nx = PS_IDLE;
        PS_IDLE: if (rise_i) st_nx = PS_RUN;
        PS_RUN:  if (lapse_i) st_nx = PS_IDLE;
        default: st_nx = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      guard <= '0;
    end else begin
      st <= st_nx;
      if (wake)
        guard <= GLOAD;
      else if (pwr_up_i && (st == PS_RUN) && rise_i && (guard != '0))
        guard <= guard - 1'b1;
    end
  end

  // R6: a low power-up pin forces off on the next cycle
  a_r6_off_next: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_i |=> st == PS_OFF);

  // R5: a rise in standby with the pin high wakes the block
  a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> st == PS_RUN);

  // R7: transmit permission is withheld right after a wake
  a_r7_guard_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !tx_en_o);

endmodule

// File: rtl/smpclk_pwr_seq.sv
module smpclk_pwr_seq
  import pcd_pkg::*;
#(
  parameter int MCLK_KHZ  = 2000,
  parameter int FAST_KHZ  = 256,
  parameter int FRAME_KHZ = 8,
  parameter int GUARD     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  input  logic pwr_up_i,
  output logic ce_fast_o,
  output logic smp_stb_o,
  output logic standby_o,
  output logic powered_o,
  output logic tx_en_o
);
  localparam int G         = gcd_i(MCLK_KHZ, FAST_KHZ);
  localparam int NUM       = FAST_KHZ / G;
  localparam int DEN       = MCLK_KHZ / G;
  localparam int FRAME_CYC = MCLK_KHZ / FRAME_KHZ;

  logic    rise;
  logic    lapse;
  logic    active;
  pwr_st_t st;

  pcd_edge_mon #(.FRAME_CYC(FRAME_CYC)) u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync_i (fsync_i),
    .run_i   (st == PS_RUN),
    .rise_o  (rise),
    .lapse_o (lapse)
  );

  pcd_pwr_seq #(.GUARD(GUARD)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_up_i (pwr_up_i),
    .rise_i   (rise),
    .lapse_i  (lapse),
    .state_o  (st),
    .active_o (active),
    .tx_en_o  (tx_en_o)
  );

  pcd_frac_div #(.NUM(NUM), .DEN(DEN)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (active),
    .restart_i (rise),
    .tick_o    (ce_fast_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) smp_stb_o <= 1'b0;
    else        smp_stb_o <= active & rise;
  end

  assign standby_o = (st == PS_IDLE);
  assign powered_o = (st == PS_RUN);

  // R3: every strobe follows a detected sync rise
  a_r3_stb_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb_o |-> $past(rise));

  // R2: the strobe coincides with a restarted fast enable
  a_r2_stb_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb_o |-> ce_fast_o);

  // R4: standby and run never overlap
  a_r4_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(standby_o && powered_o));

  // R7: transmit permission only while running
  a_r7_tx_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> powered_o);

endmodule

// File: tb/test_smpclk_pwr_seq.sv
`timescale 1ns/1ps
module test_smpclk_pwr_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic pwr_up = 1'b0;
  logic ce_fast, smp_stb, standby, powered, tx_en;

  int n_cmp = 0;
  int n_bad = 0;
  int ce_cnt = 0;
  int stb_cnt = 0;

  always #2.5 clk = ~clk;

  smpclk_pwr_seq i_smpclk_pwr_seq (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .pwr_up_i(pwr_up),
    .ce_fast_o(ce_fast), .smp_stb_o(smp_stb), .standby_o(standby),
    .powered_o(powered), .tx_en_o(tx_en)
  );

  // behavioural reference: 0 off, 1 standby, 2 running
  int  m_mode = 1;
  int  m_k = 0;      // cycles since last sync rise
  int  m_left = 0;   // sync rises still to see before transmit
  bit  m_fsprev = 0;
  bit  e_ce = 0, e_stb = 0;

  always @(posedge clk) begin
    bit r;
    if (!rst_n) begin
      m_mode = 1; m_k = 0; m_left = 0; m_fsprev = 0; e_ce = 0; e_stb = 0;
    end else begin
      r = fsync && !m_fsprev;
      m_fsprev = fsync;
      e_ce = 0; e_stb = 0;
      if (!pwr_up) m_mode = 0;
      else if (m_mode == 0) m_mode = 1;
      else if (m_mode == 1) begin
        if (r) begin m_mode = 2; m_k = 0; m_left = 2; e_ce = 1; e_stb = 1; end
      end else begin
        if (r) begin
          m_k = 0; e_ce = 1; e_stb = 1;
          if (m_left > 0) m_left--;
        end else if (m_k >= 250) m_mode = 1;
        else begin
          m_k++;
          e_ce = ((16 * m_k) / 125) != ((16 * (m_k - 1)) / 125);
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R2 ce_fast", ce_fast, e_ce);
      chk("R3 smp_stb", smp_stb, e_stb);
      chk("R4 standby", standby, m_mode == 1);
      chk("R5 powered", powered, m_mode == 2);
      chk("R7 tx_en", tx_en, (m_mode == 2) && (m_left == 0));
      ce_cnt += ce_fast;
      stb_cnt += smp_stb;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int per, int wid);
    fsync = 1'b1;
    tick(wid);
    fsync = 1'b0;
    tick(per - wid);
  endtask

  task automatic zero_cnt();
    #1;
    ce_cnt = 0;
    stb_cnt = 0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    #1;
    // R8: reset state
    chk("R8 standby", standby, 1);
    chk("R8 powered", powered, 0);
    chk("R8 tx_en", tx_en, 0);
    chk("R8 ce_fast", ce_fast, 0);
    pwr_up = 1'b1;
    tick(3);
    // R5 R7: wake from reset, guard over two frames
    frame(250, 3);
    #1 chk("R7 tx held frame1", tx_en, 0);
    frame(250, 3);
    #1 chk("R7 tx held frame2", tx_en, 0);
    frame(250, 3);
    #1 chk("R7 tx open frame3", tx_en, 1);
    // R1: pulses in one full frame
    zero_cnt();
    frame(250, 3);
    #1 chk("R1 pulses per frame", ce_cnt, 32);
    chk("R3 strobes per frame", stb_cnt, 1);
    frame(250, 1);
    frame(250, 1);
    // R4: a rise 251 edges late still keeps running
    frame(251, 2);
    #1 chk("R4 late sync keeps run", powered, 1);
    frame(250, 2);
    // R2: early sync restarts phase
    frame(100, 2);
    frame(37, 1);
    frame(250, 2);
    // R4: silence drops to standby
    fsync = 1'b0;
    tick(300);
    #1 chk("R4 standby after silence", standby, 1);
    zero_cnt();
    tick(20);
    #1 chk("R4 no enables in standby", ce_cnt, 0);
    // R5 R7: wake from standby
    frame(250, 2);
    #1 chk("R5 powered after wake", powered, 1);
    chk("R7 tx held after standby", tx_en, 0);
    frame(250, 2);
    frame(250, 2);
    #1 chk("R7 tx open after standby", tx_en, 1);
    // R3: sync held high gives one strobe only
    zero_cnt();
    fsync = 1'b1;
    tick(400);
    fsync = 1'b0;
    #1 chk("R3 single strobe held high", stb_cnt, 1);
    tick(5);
    frame(250, 2);
    // R6: power-down ignores sync
    pwr_up = 1'b0;
    zero_cnt();
    frame(250, 2);
    frame(250, 2);
    #1 chk("R6 no strobe while off", stb_cnt, 0);
    chk("R6 powered off", powered, 0);
    chk("R6 standby off", standby, 0);
    // R6: rise at pin return does not wake
    pwr_up = 1'b1;
    fsync = 1'b1;
    tick(2);
    #1 chk("R6 no wake on pin return", powered, 0);
    chk("R6 standby on pin return", standby, 1);
    fsync = 1'b0;
    tick(10);
    frame(250, 2);
    #1 chk("R5 wake after off", powered, 1);
    frame(250, 2);
    frame(250, 2);
    #1 chk("R7 tx open after off", tx_en, 1);
    tick(5);
    report();
  end

endmodule